// File: doc/BRIEF.md
# Counting Semaphore Storage Cell

This block is a single memory-mapped counting semaphore that hardware threads use to synchronize with each other. Each cycle it takes at most one request. The request carries a view select, a read/write flag, write data and the identifier of the requesting thread. Reads get a registered response that is tagged with the thread it belongs to. Writes produce no response of their own.

Two semaphore views act on a 16-bit count. A load returns the count and then takes one off it, stopping at zero. A store adds one to the count, stopping at the top value. The two views differ only in what a load does when the count is zero:

- The waiting view parks the thread in a per-thread blocked bitmap and sends no response.
- The non-waiting view answers zero at once.

When a store arrives while threads are parked, the lowest-numbered parked thread is released in that same cycle. Its load completes with the value one, so the count stays at zero. A control view reads and writes a small tag that holds an empty flag, a full flag and a read-only cell-type bit.

The control logic is a four-state machine, advanced on every clock edge:

| State | Condition |
|---|---|
| ST_EMPTY | count is zero and no thread is parked |
| ST_WAIT | count is zero and at least one thread is parked |
| ST_AVAIL | count lies strictly between zero and the top value |
| ST_SAT | count is at 0xFFFF |

Transitions:

- ST_EMPTY to ST_AVAIL: on a store.
- ST_EMPTY to ST_WAIT: on a waiting-view load.
- ST_WAIT to ST_EMPTY: on a store that releases the last parked thread.
- ST_WAIT stays in ST_WAIT: on a store while other threads remain parked.
- ST_AVAIL to ST_EMPTY: on a load that takes the count from one to zero.
- ST_AVAIL to ST_SAT: on a store that brings the count to the top value.
- ST_SAT to ST_AVAIL: on a load.
- ST_SAT stays in ST_SAT: on a store.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the blocked bitmap is all zeros, no response is valid, and the tag reads 0x0001 (empty flag set, full flag clear).
- R2: A load through view 2'b01 (waiting) or 2'b10 (non-waiting) while the count is non-zero returns the count and decrements it by one.
- R3: A store through view 2'b01 or 2'b10 increments the count and saturates at 0xFFFF.
- R4: A load through view 2'b10 while the count is zero returns 0, leaves the count at 0, and blocks no thread.
- R5: A load through view 2'b01 while the count is zero produces no response and sets bit `req_tid` of `blocked_map`.
- R6: A store while any thread is blocked releases the lowest-numbered blocked thread, which gets a response with data 1 one cycle later. That thread's bit is cleared, and the count stays 0.
- R7: View 2'b00 is the control view. A read returns the tag with empty at bit 0, full at bit 1, the cell-type bit at bit 2 (always 0), and zeros above. A write loads bits 1:0 from `req_wdata[1:0]` and ignores every other bit.
- R8: Loads and stores through the semaphore views leave the empty and full tag bits unchanged.
- R9: A request from a thread whose `blocked_map` bit is set is ignored. It gets no response, and the count, tag and bitmap do not change.
- R10: A read response appears in the cycle after the request, with `rsp_tid` equal to the requester (or to the released thread, for R6).
- R11: View 2'b11 is reserved. Requests through it give no response and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_view | input | 2 | View select: 00 control, 01 waiting, 10 non-waiting, 11 reserved |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | CNT_W (16) | Write data; only bits 1:0 are used, by control writes |
| req_tid | input | TID_W (3) | Requesting thread |
| rsp_valid | output | 1 | Read response valid |
| rsp_tid | output | TID_W (3) | Thread the response belongs to |
| rsp_data | output | CNT_W (16) | Returned count or tag |
| blocked_map | output | THREADS (8) | One bit per thread parked on the cell |

## Verification
Suppose the machine's state disagrees with the count. For example, it might hold ST_AVAIL while the count is zero. The next load at zero then either returns a stale non-zero value or fails to park the thread, and this shows on `rsp_valid` and `blocked_map` one cycle after the request. A count that wraps instead of saturating shows only when a load follows. So the saturation scenario reads the count right after the extra stores. A mistake in the release priority shows at once: the first store while two threads are parked reports the wrong `rsp_tid`, and the remaining `blocked_map` bit is wrong.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        VIEW_CTRL = 2'b00,
        VIEW_WAIT = 2'b01,
        VIEW_TRY  = 2'b10,
        VIEW_RSVD = 2'b11
    } view_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_WAIT  = 2'b01,
        ST_AVAIL = 2'b10,
        ST_SAT   = 2'b11
    } cell_state_e;

    localparam int TAG_FLAG_W  = 2;
    localparam int TAG_EMPTY_B = 0;
    localparam int TAG_FULL_B  = 1;
    localparam int TAG_TYPE_B  = 2;

endpackage

// File: rtl/sem_counter.sv
module sem_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_comb begin
        cnt_nxt = cnt_q;
        if (inc && !dec) begin
            if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + W'(1);
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_nxt = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/sem_waitq.sv
module sem_waitq #(
    parameter int N  = 8,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [TW-1:0] set_tid,
    input  logic          rel_en,
    output logic [N-1:0]  map_q,
    output logic [N-1:0]  map_nxt,
    output logic [TW-1:0] low_tid
);
    always_comb begin
        low_tid = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (map_q[i]) low_tid = TW'(i);
        end
    end

    always_comb begin
        map_nxt = map_q;
        if (set_en) map_nxt[set_tid] = 1'b1;
        if (rel_en) map_nxt[low_tid] = 1'b0;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) map_q[g] <= 1'b0;
            else        map_q[g] <= map_nxt[g];
        end
    end
endmodule

// File: rtl/sem_tag.sv
module sem_tag
    import sem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TAG_FLAG_W-1:0] wr_bits,
    output logic [TAG_FLAG_W-1:0] flags_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q              <= '0;
            flags_q[TAG_EMPTY_B] <= 1'b1;
        end else if (wr_en) begin
            flags_q <= wr_bits;
        end
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter int THREADS = 8,
    parameter int CNT_W   = 16,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_view,
    input  logic               req_write,
    input  logic [CNT_W-1:0]   req_wdata,
    input  logic [TID_W-1:0]   req_tid,
    output logic               rsp_valid,
    output logic [TID_W-1:0]   rsp_tid,
    output logic [CNT_W-1:0]   rsp_data,
    output logic [THREADS-1:0] blocked_map
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cell_state_e state_q, state_nxt;
    view_e       view;

    logic [CNT_W-1:0]      cnt_q, cnt_nxt;
    logic [THREADS-1:0]    map_q, map_nxt;
    logic [TID_W-1:0]      low_tid;
    logic [TAG_FLAG_W-1:0] flags_q;
    logic [CNT_W-1:0]      tag_word;

    logic accept, is_pv, pv_rd, pv_wr, ctrl_rd, ctrl_wr;
    logic cnt_zero, have_waiters;
    logic do_inc, do_dec, do_block, do_release;
    logic rsp_v_nxt;
    logic [TID_W-1:0] rsp_tid_nxt;
    logic [CNT_W-1:0] rsp_data_nxt;
    logic unused_wdata;

    assign view         = view_e'(req_view);
    assign unused_wdata = ^req_wdata[CNT_W-1:TAG_FLAG_W];

    // A request counts only if its thread is not parked and its view is defined
    assign accept  = req_valid && !map_q[req_tid] && (view != VIEW_RSVD);
    assign is_pv   = (view == VIEW_WAIT) || (view == VIEW_TRY);
    assign pv_rd   = accept && is_pv && !req_write;
    assign pv_wr   = accept && is_pv && req_write;
    assign ctrl_rd = accept && (view == VIEW_CTRL) && !req_write;
    assign ctrl_wr = accept && (view == VIEW_CTRL) && req_write;

    always_comb begin
        tag_word                          = '0;
        tag_word[TAG_FLAG_W-1:0]          = flags_q;
        tag_word[TAG_TYPE_B]              = 1'b0;
    end

    sem_counter #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (do_inc),
        .dec     (do_dec),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    sem_waitq #(.N(THREADS), .TW(TID_W)) u_waitq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (do_block),
        .set_tid (req_tid),
        .rel_en  (do_release),
        .map_q   (map_q),
        .map_nxt (map_nxt),
        .low_tid (low_tid)
    );

    sem_tag u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_bits (req_wdata[TAG_FLAG_W-1:0]),
        .flags_q (flags_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_nxt;
    end

    // Next state follows the count and bitmap values being loaded this cycle
    always_comb begin
        if (cnt_nxt == '0)          state_nxt = (|map_nxt) ? ST_WAIT : ST_EMPTY;
        else if (cnt_nxt == CNT_MAX) state_nxt = ST_SAT;
        else                         state_nxt = ST_AVAIL;
    end

    // Outputs and datapath controls decoded from the current state
    always_comb begin
        cnt_zero     = 1'b0;
        have_waiters = 1'b0;
        unique case (state_q)
            ST_EMPTY: cnt_zero = 1'b1;
            ST_WAIT: begin
                cnt_zero     = 1'b1;
                have_waiters = 1'b1;
            end
            ST_AVAIL: cnt_zero = 1'b0;
            ST_SAT:   cnt_zero = 1'b0;
        endcase

        do_release   = pv_wr && have_waiters;
        do_inc       = pv_wr;
        do_dec       = (pv_rd && !cnt_zero) || do_release;
        do_block     = pv_rd && cnt_zero && (view == VIEW_WAIT);

        rsp_v_nxt    = 1'b0;
        rsp_tid_nxt  = req_tid;
        rsp_data_nxt = '0;
        if (ctrl_rd) begin
            rsp_v_nxt    = 1'b1;
            rsp_data_nxt = tag_word;
        end else if (pv_rd && !cnt_zero) begin
            rsp_v_nxt    = 1'b1;
            rsp_data_nxt = cnt_q;
        end else if (pv_rd && (view == VIEW_TRY)) begin
            rsp_v_nxt    = 1'b1;
            rsp_data_nxt = '0;
        end else if (do_release) begin
            rsp_v_nxt    = 1'b1;
            rsp_tid_nxt  = low_tid;
            rsp_data_nxt = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rsp_v_nxt;
            rsp_tid   <= rsp_tid_nxt;
            rsp_data  <= rsp_data_nxt;
        end
    end

    assign blocked_map = map_q;
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk
    import sem_pkg::*;
#(
    parameter int THREADS = 8,
    parameter int CNT_W   = 16,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [1:0]            req_view,
    input logic                  req_write,
    input logic [TID_W-1:0]      req_tid,
    input logic                  rsp_valid,
    input logic [CNT_W-1:0]      rsp_data,
    input logic [THREADS-1:0]    blocked_map,
    input logic [CNT_W-1:0]      cnt_q,
    input logic [TAG_FLAG_W-1:0] flags_q,
    input logic [1:0]            state_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic acc, pv;
    assign acc = req_valid && !blocked_map[req_tid] && (req_view != 2'b11);
    assign pv  = (req_view == 2'b01) || (req_view == 2'b10);

    a_r2_load_returns_and_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pv && !req_write && cnt_q != '0)
        |=> (rsp_valid && rsp_data == $past(cnt_q) && cnt_q == $past(cnt_q) - CNT_W'(1)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pv && req_write && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    a_r4_try_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_view == 2'b10 && !req_write && cnt_q == '0)
        |=> (rsp_valid && rsp_data == '0 && cnt_q == '0 && $stable(blocked_map)));

    a_r5_wait_parks_thread: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_view == 2'b01 && !req_write && cnt_q == '0)
        |=> (!rsp_valid && blocked_map[$past(req_tid)]));

    a_r6_parked_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|blocked_map) |-> (cnt_q == '0 && state_q == ST_WAIT));

    a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pv) |=> $stable(flags_q));

    a_r9_parked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && blocked_map[req_tid])
        |=> (!rsp_valid && $stable(cnt_q) && $stable(flags_q) && $stable(blocked_map)));
endmodule

bind sem_cell sem_cell_chk #(.THREADS(THREADS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_view    (req_view),
    .req_write   (req_write),
    .req_tid     (req_tid),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .blocked_map (blocked_map),
    .cnt_q       (cnt_q),
    .flags_q     (flags_q),
    .state_q     (state_q)
);

// File: tb/sem_cell_tb.sv
module sem_cell_tb;
    localparam int THREADS = 8;
    localparam int CNT_W   = 16;
    localparam int TID_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [1:0]         req_view = 2'b00;
    logic               req_write = 1'b0;
    logic [CNT_W-1:0]   req_wdata = '0;
    logic [TID_W-1:0]   req_tid = '0;
    logic               rsp_valid;
    logic [TID_W-1:0]   rsp_tid;
    logic [CNT_W-1:0]   rsp_data;
    logic [THREADS-1:0] blocked_map;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic             got_v;
    logic [TID_W-1:0] got_tid;
    logic [CNT_W-1:0] got_d;

    always #5 clk = ~clk;

    sem_cell #(.THREADS(THREADS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_wdata(req_wdata), .req_tid(req_tid),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
        .blocked_map(blocked_map)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one request at a negedge; capture the response at the following negedge
    task automatic issue(input logic [1:0] view, input logic wr, input logic [CNT_W-1:0] wd,
                         input logic [TID_W-1:0] tid);
        req_valid = 1'b1;
        req_view  = view;
        req_write = wr;
        req_wdata = wd;
        req_tid   = tid;
        @(negedge clk);
        req_valid = 1'b0;
        got_v   = rsp_valid;
        got_tid = rsp_tid;
        got_d   = rsp_data;
    endtask

    task automatic read_expect(input logic [1:0] view, input logic [TID_W-1:0] tid,
                               input logic [CNT_W-1:0] exp, input string req);
        issue(view, 1'b0, '0, tid);
        chk(got_v == 1'b1, {req, " valid"}, got_v, 1);
        chk(got_tid == tid, {req, " R10 tid"}, got_tid, tid);
        chk(got_d == exp, {req, " data"}, got_d, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        chk(blocked_map == '0, "R1 blocked_map after reset", blocked_map, 0);
        read_expect(2'b00, 3'd1, 16'h0001, "R1 tag after reset");
        read_expect(2'b10, 3'd1, 16'h0000, "R1 count after reset");
    endtask

    task automatic t_pv_basic();
        do_reset();
        issue(2'b01, 1'b1, 16'hBEEF, 3'd0);
        chk(got_v == 1'b0, "R3 store has no response", got_v, 0);
        issue(2'b01, 1'b1, '0, 3'd3);
        issue(2'b10, 1'b1, '0, 3'd6);
        issue(2'b10, 1'b1, '0, 3'd7);
        read_expect(2'b01, 3'd4, 16'd4, "R2 R3 wait-view load");
        read_expect(2'b10, 3'd2, 16'd3, "R2 try-view load");
        read_expect(2'b01, 3'd7, 16'd2, "R2 second decrement");
        read_expect(2'b10, 3'd0, 16'd1, "R2 last unit");
        read_expect(2'b10, 3'd0, 16'd0, "R2 count reached zero");
    endtask

    task automatic t_try_zero();
        do_reset();
        read_expect(2'b10, 3'd3, 16'd0, "R4 try at zero");
        chk(blocked_map == '0, "R4 no thread parked", blocked_map, 0);
        read_expect(2'b10, 3'd3, 16'd0, "R4 count stays zero");
    endtask

    task automatic t_park_release();
        do_reset();
        issue(2'b01, 1'b0, '0, 3'd5);
        chk(got_v == 1'b0, "R5 no response when parked", got_v, 0);
        chk(blocked_map == 8'h20, "R5 bit 5 parked", blocked_map, 8'h20);
        issue(2'b01, 1'b0, '0, 3'd2);
        chk(blocked_map == 8'h24, "R5 bit 2 parked", blocked_map, 8'h24);
        issue(2'b10, 1'b1, '0, 3'd5);
        chk(got_v == 1'b0, "R9 parked thread store ignored", got_v, 0);
        chk(blocked_map == 8'h24, "R9 bitmap unchanged", blocked_map, 8'h24);
        issue(2'b00, 1'b0, '0, 3'd2);
        chk(got_v == 1'b0, "R9 parked thread read ignored", got_v, 0);
        issue(2'b10, 1'b1, '0, 3'd0);
        chk(got_v == 1'b1 && got_tid == 3'd2 && got_d == 16'd1, "R6 lowest released first",
            {got_v, 5'b0, got_tid, got_d}, {1'b1, 5'b0, 3'd2, 16'd1});
        chk(blocked_map == 8'h20, "R6 bit 2 cleared", blocked_map, 8'h20);
        issue(2'b01, 1'b1, '0, 3'd1);
        chk(got_v == 1'b1 && got_tid == 3'd5 && got_d == 16'd1, "R6 second release",
            {got_v, 5'b0, got_tid, got_d}, {1'b1, 5'b0, 3'd5, 16'd1});
        chk(blocked_map == 8'h00, "R6 bitmap empty", blocked_map, 0);
        read_expect(2'b10, 3'd0, 16'd0, "R6 count stayed zero");
    endtask

    task automatic t_ctrl();
        do_reset();
        issue(2'b00, 1'b1, 16'hFFFE, 3'd1);
        chk(got_v == 1'b0, "R7 control write no response", got_v, 0);
        read_expect(2'b00, 3'd1, 16'h0002, "R7 only bits 1:0 written");
        issue(2'b00, 1'b1, 16'h0007, 3'd1);
        read_expect(2'b00, 3'd1, 16'h0003, "R7 type bit reads 0");
        issue(2'b01, 1'b1, '0, 3'd2);
        issue(2'b10, 1'b1, '0, 3'd2);
        read_expect(2'b01, 3'd2, 16'd2, "R8 pv load");
        read_expect(2'b00, 3'd1, 16'h0003, "R8 flags unchanged by pv");
        read_expect(2'b10, 3'd2, 16'd1, "R7 control access left count");
    endtask

    task automatic t_reserved();
        do_reset();
        issue(2'b11, 1'b1, 16'h0002, 3'd1);
        issue(2'b11, 1'b0, '0, 3'd1);
        chk(got_v == 1'b0, "R11 reserved read silent", got_v, 0);
        read_expect(2'b00, 3'd1, 16'h0001, "R11 tag unchanged");
        read_expect(2'b10, 3'd1, 16'd0, "R11 count unchanged");
    endtask

    task automatic t_saturate();
        do_reset();
        req_valid = 1'b1;
        req_view  = 2'b10;
        req_write = 1'b1;
        req_tid   = 3'd4;
        repeat (65535 + 3) @(negedge clk);
        req_valid = 1'b0;
        read_expect(2'b10, 3'd4, 16'hFFFF, "R3 saturated at max");
        read_expect(2'b01, 3'd4, 16'hFFFE, "R3 R2 decrement from max");
    endtask

    initial begin
        t_reset();
        t_pv_basic();
        t_try_zero();
        t_park_release();
        t_ctrl();
        t_reserved();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule